// File: doc/BRIEF.md
# Timer Capture/Compare Channel with Fractional Dithering

One channel of a general-purpose timer. In output mode it compares an externally supplied counter value against an active compare register and drives a PWM-style compare output. Software loads the compare value through a 20-bit register. With preload off the value takes effect at once; with preload on it is held in a shadow and moved into the active register on the next update event.

In input mode the channel latches the counter value into the same register on each capture event and ignores software writes. A capture flag and an overcapture flag report pending and lost captures. Both flags clear on a register read.

With dithering on, the register holds a 16-bit integer compare value in its upper field and a 4-bit fraction in its lower field. The channel adds one to the integer part in F of every 16 counter periods. It spreads those periods evenly by indexing a bit-reversed pattern with a period counter that advances on update events. The average duty cycle therefore gains a resolution of 1/16 count.

Top module: `tmr_ccx_chan`

## Requirements
- R1: After reset the register reads zero, both flags are low, the period index is zero and the compare output is low.
- R2: The read port is 32 bits wide. Bits 31:20 always read zero, and writes to them are ignored.
- R3: In output mode with preload off, a write reaches the active compare value on the clock edge that accepts it.
- R4: In output mode with preload on, a write changes only the shadow (and the readback). The active compare value takes the shadow value on the next update event.
- R5: With dithering off, a written value keeps bits 15:0 and forces bits 19:16 to zero. The compare uses bits 15:0.
- R6: In output mode the compare output is high exactly while the counter is below the effective compare value. In input mode it stays low.
- R7: With dithering on, the integer part is bits 19:4 and the fraction F is bits 3:0. The effective compare value is the integer plus one when the 4-bit bit-reverse of the period index is below F, and the integer otherwise. This gives exactly F raised periods in every 16 consecutive ones, and with an integer of 0xFFFF the raised value is 0x10000.
- R8: In input mode a capture event loads the counter into bits 15:0 with dithering off, or into bits 19:4 with dithering on. All other bits read zero.
- R9: In input mode register writes have no effect on the register.
- R10: A capture event sets the capture flag. A read pulse clears it, unless a capture arrives in the same cycle.
- R11: A capture arriving while the capture flag is already set, with no read in that cycle, sets the overcapture flag. A read pulse clears it.
- R12: The period index advances by one, modulo 16, on each update event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_i | input | 16 | Timer counter value |
| upd_i | input | 1 | Update event pulse |
| cap_i | input | 1 | Capture event pulse |
| in_mode_i | input | 1 | 1 = input capture, 0 = output compare |
| pre_en_i | input | 1 | Preload enable |
| dith_en_i | input | 1 | Dithering enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 32 | Register write data |
| rd_en_i | input | 1 | Register read pulse (clears flags) |
| rd_data_o | output | 32 | Register readback |
| cmp_o | output | 1 | Compare output |
| cap_flag_o | output | 1 | Capture pending flag |
| ovr_flag_o | output | 1 | Overcapture flag |

## Verification
The bench builds the channel with its default widths: a 16-bit counter, a 4-bit fraction and a 32-bit data port. The counter is driven directly from the bench, so the full-scale integer 0xFFFF and its dithered value 0x10000 can be reached without running a counter. A 16-period dither sweep fits in a few hundred cycles, which allows several fractions, including 0 and 15, to be checked for their exact count of raised periods and for their placement.

// File: rtl/tmr_ccx_pkg.sv
package tmr_ccx_pkg;
  typedef enum logic {
    CH_OUT = 1'b0,
    CH_IN  = 1'b1
  } ch_mode_e;
endpackage

// File: rtl/tmr_ccx_regs.sv
module tmr_ccx_regs
  import tmr_ccx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  ch_mode_e         mode_i,
  input  logic             pre_en_i,
  input  logic             dith_en_i,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_raw_i,
  input  logic             upd_i,
  input  logic             cap_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             rd_en_i,
  output logic [REG_W-1:0] pre_o,
  output logic [REG_W-1:0] act_o,
  output logic             cap_flag_o,
  output logic             ovr_flag_o
);
  logic [REG_W-1:0] pre_q, act_q, wr_val, cap_val;
  logic             cap_flag_q, ovr_flag_q;
  logic             out_wr, in_cap;

  // field layout follows dithering mode
  always_comb begin
    if (dith_en_i) begin
      wr_val  = wr_raw_i;
      cap_val = {cnt_i, {FRAC_W{1'b0}}};
    end else begin
      wr_val  = {{FRAC_W{1'b0}}, wr_raw_i[CNT_W-1:0]};
      cap_val = {{FRAC_W{1'b0}}, cnt_i};
    end
  end

  assign out_wr = wr_en_i && (mode_i == CH_OUT);
  assign in_cap = cap_i && (mode_i == CH_IN);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre_q <= '0;
    end else if (out_wr) begin
      pre_q <= wr_val;
    end else if (in_cap) begin
      pre_q <= cap_val;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (mode_i == CH_OUT) begin
      if (pre_en_i) begin
        if (upd_i) act_q <= pre_q;
      end else if (wr_en_i) begin
        act_q <= wr_val;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cap_flag_q <= 1'b0;
      ovr_flag_q <= 1'b0;
    end else begin
      if (in_cap)       cap_flag_q <= 1'b1;
      else if (rd_en_i) cap_flag_q <= 1'b0;
      if (in_cap && cap_flag_q && !rd_en_i) ovr_flag_q <= 1'b1;
      else if (rd_en_i)                     ovr_flag_q <= 1'b0;
    end
  end

  assign pre_o      = pre_q;
  assign act_o      = act_q;
  assign cap_flag_o = cap_flag_q;
  assign ovr_flag_o = ovr_flag_q;
endmodule

// File: rtl/tmr_ccx_dither.sv
module tmr_ccx_dither #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_i,
  input  logic              dith_en_i,
  input  logic [REG_W-1:0]  act_i,
  output logic [CNT_W:0]    eff_o,
  output logic [FRAC_W-1:0] idx_o
);
  logic [FRAC_W-1:0] idx_q, idx_rev;
  logic              bump;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    idx_q <= '0;
    else if (upd_i) idx_q <= idx_q + 1'b1;
  end

  // bit-reversed index spreads raised periods evenly
  for (genvar g = 0; g < FRAC_W; g++) begin : g_rev
    assign idx_rev[g] = idx_q[FRAC_W-1-g];
  end

  assign bump = idx_rev < act_i[FRAC_W-1:0];

  always_comb begin
    if (dith_en_i)
      eff_o = {1'b0, act_i[REG_W-1:FRAC_W]} + (CNT_W+1)'(bump);
    else
      eff_o = {1'b0, act_i[CNT_W-1:0]};
  end

  assign idx_o = idx_q;
endmodule

// File: rtl/tmr_ccx_cmp.sv
module tmr_ccx_cmp
  import tmr_ccx_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  ch_mode_e       mode_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W:0]   eff_i,
  output logic             cmp_o
);
  assign cmp_o = (mode_i == CH_OUT) && ({1'b0, cnt_i} < eff_i);
endmodule

// File: rtl/tmr_ccx_chan.sv
module tmr_ccx_chan
  import tmr_ccx_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int DATA_W = 32,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              upd_i,
  input  logic              cap_i,
  input  logic              in_mode_i,
  input  logic              pre_en_i,
  input  logic              dith_en_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_en_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              cmp_o,
  output logic              cap_flag_o,
  output logic              ovr_flag_o
);
  ch_mode_e          mode;
  logic [REG_W-1:0]  pre_q, act_q;
  logic [CNT_W:0]    eff;
  logic [FRAC_W-1:0] idx_q;

  assign mode = in_mode_i ? CH_IN : CH_OUT;

  tmr_ccx_regs #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .pre_en_i   (pre_en_i),
    .dith_en_i  (dith_en_i),
    .wr_en_i    (wr_en_i),
    .wr_raw_i   (wr_data_i[REG_W-1:0]),
    .upd_i      (upd_i),
    .cap_i      (cap_i),
    .cnt_i      (cnt_i),
    .rd_en_i    (rd_en_i),
    .pre_o      (pre_q),
    .act_o      (act_q),
    .cap_flag_o (cap_flag_o),
    .ovr_flag_o (ovr_flag_o)
  );

  tmr_ccx_dither #(.CNT_W(CNT_W), .FRAC_W(FRAC_W)) u_dither (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_i     (upd_i),
    .dith_en_i (dith_en_i),
    .act_i     (act_q),
    .eff_o     (eff),
    .idx_o     (idx_q)
  );

  tmr_ccx_cmp #(.CNT_W(CNT_W)) u_cmp (
    .mode_i (mode),
    .cnt_i  (cnt_i),
    .eff_i  (eff),
    .cmp_o  (cmp_o)
  );

  assign rd_data_o = {{(DATA_W-REG_W){1'b0}}, pre_q};
endmodule

// File: rtl/tmr_ccx_chan_chk.sv
module tmr_ccx_chan_chk #(
  parameter int CNT_W  = 16,
  parameter int FRAC_W = 4,
  parameter int DATA_W = 32,
  localparam int REG_W = CNT_W + FRAC_W
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [CNT_W-1:0]  cnt_i,
  input logic              upd_i,
  input logic              cap_i,
  input logic              in_mode_i,
  input logic              pre_en_i,
  input logic              dith_en_i,
  input logic              wr_en_i,
  input logic              rd_en_i,
  input logic [DATA_W-1:0] rd_data_o,
  input logic              cmp_o,
  input logic              cap_flag_o,
  input logic              ovr_flag_o,
  input logic [REG_W-1:0]  pre_q,
  input logic [REG_W-1:0]  act_q,
  input logic [FRAC_W-1:0] idx_q
);
  assert_rsvd_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[DATA_W-1:REG_W] == '0);

  assert_direct_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_mode_i && !pre_en_i && wr_en_i) |=> act_q == pre_q);

  assert_cmp_plain_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!in_mode_i && !dith_en_i) |-> cmp_o == (cnt_i < act_q[CNT_W-1:0]));

  assert_cmp_in_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_mode_i |-> !cmp_o);

  assert_cap_val_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_mode_i && cap_i && !dith_en_i) |=> rd_data_o == DATA_W'($past(cnt_i)));

  assert_wr_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_mode_i && !cap_i) |=> $stable(rd_data_o));

  assert_flag_clr_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !cap_i) |=> !cap_flag_o && !ovr_flag_o);

  assert_ovr_cause_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ovr_flag_o) |-> $past(cap_flag_o) && $past(cap_i));

  assert_idx_step_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> idx_q == FRAC_W'($past(idx_q) + 1'b1));
endmodule

bind tmr_ccx_chan tmr_ccx_chan_chk #(.CNT_W(CNT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cnt_i      (cnt_i),
  .upd_i      (upd_i),
  .cap_i      (cap_i),
  .in_mode_i  (in_mode_i),
  .pre_en_i   (pre_en_i),
  .dith_en_i  (dith_en_i),
  .wr_en_i    (wr_en_i),
  .rd_en_i    (rd_en_i),
  .rd_data_o  (rd_data_o),
  .cmp_o      (cmp_o),
  .cap_flag_o (cap_flag_o),
  .ovr_flag_o (ovr_flag_o),
  .pre_q      (pre_q),
  .act_q      (act_q),
  .idx_q      (idx_q)
);

// File: tb/tmr_ccx_chan_bench.sv
`timescale 1ns/1ps
module tmr_ccx_chan_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        upd = 1'b0, cap = 1'b0, in_mode = 1'b0, pre_en = 1'b0, dith_en = 1'b0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic        cmp, cap_flag, ovr_flag;
  int          total = 0, bad = 0;
  bit          done = 1'b0;
  int          upd_cnt = 0;

  always #2.5 clk = ~clk;

  tmr_ccx_chan u_tmr_ccx_chan (
    .clk_i(clk), .rst_ni(rst_n), .cnt_i(cnt), .upd_i(upd), .cap_i(cap),
    .in_mode_i(in_mode), .pre_en_i(pre_en), .dith_en_i(dith_en),
    .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
    .rd_data_o(rd_data), .cmp_o(cmp), .cap_flag_o(cap_flag), .ovr_flag_o(ovr_flag)
  );

  function automatic logic [3:0] rev4(input logic [3:0] v);
    return {v[0], v[1], v[2], v[3]};
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic tick;
    @(posedge clk); #1;
  endtask

  task automatic do_reset;
    rst_n = 1'b0; upd = 0; cap = 0; wr_en = 0; rd_en = 0; cnt = '0;
    in_mode = 0; pre_en = 0; dith_en = 0; upd_cnt = 0;
    tick; tick;
    rst_n = 1'b1;
    tick;
  endtask

  task automatic write(input logic [31:0] d);
    wr_data = d; wr_en = 1'b1; tick; wr_en = 1'b0;
  endtask

  task automatic pulse_upd;
    upd = 1'b1; tick; upd = 1'b0; upd_cnt++;
  endtask

  task automatic t_reset;
    do_reset;
    cnt = 16'h0000; #1;
    chk("R1 readback", rd_data, 32'h0);
    chk("R1 flags", {30'h0, cap_flag, ovr_flag}, 32'h0);
    chk("R1 cmp low", {31'h0, cmp}, 32'h0);
  endtask

  task automatic t_rsvd;
    do_reset;
    dith_en = 1'b1;
    write(32'hFFFF_FFFF);
    chk("R2 upper bits zero", rd_data, 32'h000F_FFFF);
    dith_en = 1'b0;
    write(32'hFFFA_BCDE);
    chk("R5 bits 19:16 forced zero", rd_data, 32'h0000_BCDE);
  endtask

  task automatic t_nopre;
    do_reset;
    write(32'd100);
    cnt = 16'd99;  #1; chk("R3/R6 below", {31'h0, cmp}, 32'h1);
    cnt = 16'd100; #1; chk("R6 equal", {31'h0, cmp}, 32'h0);
    cnt = 16'd0;   #1; chk("R6 zero", {31'h0, cmp}, 32'h1);
    write(32'h0005_0000);
    cnt = 16'd0;   #1; chk("R5 compare uses 15:0", {31'h0, cmp}, 32'h0);
  endtask

  task automatic t_pre;
    do_reset;
    pre_en = 1'b1;
    write(32'd50);
    chk("R4 readback shadow", rd_data, 32'd50);
    cnt = 16'd10; #1; chk("R4 active unchanged", {31'h0, cmp}, 32'h0);
    pulse_upd;
    cnt = 16'd10; #1; chk("R4 active after update", {31'h0, cmp}, 32'h1);
    cnt = 16'd50; #1; chk("R4 edge", {31'h0, cmp}, 32'h0);
  endtask

  task automatic t_dither(input logic [15:0] ip, input logic [3:0] fr);
    int ones = 0;
    logic exp_b;
    do_reset;
    dith_en = 1'b1;
    write({12'h0, ip, fr});
    for (int p = 0; p < 16; p++) begin
      exp_b = rev4(4'(upd_cnt)) < fr;
      cnt = ip; #1;
      chk($sformatf("R7 period %0d frac %0d", p, fr), {31'h0, cmp}, {31'h0, exp_b});
      if (cmp) ones++;
      pulse_upd;
    end
    chk($sformatf("R7/R12 raised count frac %0d", fr), ones, {28'h0, fr});
  endtask

  task automatic t_dither_top;
    do_reset;
    dith_en = 1'b1;
    write({12'h0, 16'hFFFF, 4'hF});
    cnt = 16'hFFFF; #1;
    chk("R7 raised to 0x10000", {31'h0, cmp}, 32'h1);
    for (int p = 0; p < 15; p++) pulse_upd;
    cnt = 16'hFFFF; #1;
    chk("R7/R12 index 15 not raised", {31'h0, cmp}, 32'h0);
  endtask

  task automatic t_capture;
    do_reset;
    in_mode = 1'b1;
    cnt = 16'h1234; cap = 1'b1; tick; cap = 1'b0;
    chk("R8 capture plain", rd_data, 32'h0000_1234);
    chk("R10 flag set", {31'h0, cap_flag}, 32'h1);
    chk("R6 cmp low in input", {31'h0, cmp}, 32'h0);
    write(32'h0000_5555);
    chk("R9 write ignored", rd_data, 32'h0000_1234);
    rd_en = 1'b1; tick; rd_en = 1'b0;
    chk("R10 flag cleared", {31'h0, cap_flag}, 32'h0);
    dith_en = 1'b1;
    cnt = 16'hABCD; cap = 1'b1; tick; cap = 1'b0;
    chk("R8 capture dithered", rd_data, 32'h000A_BCD0);
    chk("R11 no overcapture yet", {31'h0, ovr_flag}, 32'h0);
    cnt = 16'h0042; cap = 1'b1; tick; cap = 1'b0;
    chk("R11 overcapture set", {31'h0, ovr_flag}, 32'h1);
    chk("R8 second capture", rd_data, 32'h0000_0420);
    rd_en = 1'b1; tick; rd_en = 1'b0;
    chk("R11 overcapture cleared", {30'h0, cap_flag, ovr_flag}, 32'h0);
  endtask

  initial begin
    t_reset;
    t_rsvd;
    t_nopre;
    t_pre;
    t_dither(16'd1000, 4'd0);
    t_dither(16'd1000, 4'd1);
    t_dither(16'd1000, 4'd5);
    t_dither(16'd1000, 4'd8);
    t_dither(16'd1000, 4'd15);
    t_dither_top;
    t_capture;
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog got=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule